// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits between a two-wire serial slave front end and a 512-byte nonvolatile array. The front end supplies byte-level events: a write command carrying its 9-bit start location, one strobe per data byte at the moment bit 0 of that byte is sampled, the data bytes themselves, and the stop condition. The controller gathers the bytes into a 16-byte page buffer and writes the whole page with one wide memory write when a timed internal write cycle ends. While that cycle runs, `busy` tells the protocol engine to refuse every new command.

The 9-bit location is the page-select bit above an 8-bit word address. Bits [8:4] choose the page and stay fixed for the whole command. Bits [3:0] choose the first slot, and the slot index wraps modulo 16. A write-protect input blocks every rewrite. Once bit 0 of the first data byte has been sampled, it also cancels the command or the internal write already under way. A cancelled internal write fills the slots it was targeting with a marker byte and returns to standby on the next clock. The write time is a cycle count parameter (`TWR_CYCLES`), so a simulation can use a short value.

The data input is a valid/ready stream. `in_ready` is high only while a command is collecting bytes. The source must hold `in_valid` and `in_data` until a cycle in which both are high; a byte offered at any other time is not taken. The memory port has no back-pressure.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `busy`, `in_ready` and `mem_we` are all low.
- R2: A `cmd_valid` pulse while not busy opens a command, and `in_ready` is high from the next cycle. Each byte accepted by the handshake is stored in the page buffer.
- R3: Byte k of a command goes to slot (start[3:0] + k) mod 16 of page start[8:4]. For example, a start at word 0x0E fills slots 0x0E, 0x0F, 0x00, 0x01.
- R4: When more than 16 bytes arrive, byte 16 and later overwrite slots again, beginning at the first slot loaded.
- R5: Nothing is written before the stop. A stop with at least one byte loaded and `wp` low makes `busy` high for exactly `TWR_CYCLES` cycles. On the cycle `busy` falls, `mem_we` pulses for one cycle and carries the whole page.
- R6: A stop with no byte loaded writes nothing and leaves `busy` low.
- R7: `wp` high before the first bit-0 strobe of a command is ignored. If it is low again by the stop, the page is written normally.
- R8: `wp` high at or after the first bit-0 strobe, while bytes are still being collected, drops the command. `in_ready` falls on the next cycle, and no write and no busy period follow.
- R9: `wp` high during a busy cycle ends that cycle on the next clock. `busy` falls, and one write stores `MARKER` (default 0xEE) into every slot loaded by the command. A new command is accepted at once. This holds even on the final busy cycle.
- R10: While busy, `cmd_valid` is ignored: `in_ready` stays low and the write in progress completes at its normal time.
- R11: The byte-enable mask `mem_be` (bit i for slot i) of each write has exactly the slots loaded by the command set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Start of a write command, one-cycle pulse |
| cmd_addr | input | 9 | Start location: page-select bit plus word address |
| d0_strobe | input | 1 | Pulse when bit 0 of a data byte is sampled |
| in_valid | input | 1 | Data byte offered |
| in_ready | output | 1 | Controller accepts a data byte |
| in_data | input | 8 | Data byte |
| stop_strobe | input | 1 | Stop condition seen, one-cycle pulse |
| wp | input | 1 | Write protect, high blocks or cancels writes |
| busy | output | 1 | Internal write cycle running |
| mem_we | output | 1 | Page write to the array, one-cycle pulse |
| mem_page | output | 5 | Page number for the write |
| mem_be | output | 16 | Byte-enable mask, one bit per slot |
| mem_wdata | output | 128 | Page data, slot i in bits [8i+7:8i] |

## Verification
Two things can happen in the same cycle: the timer reaching its last busy cycle, and a write-protect cancel. The bench raises `wp` for exactly the final busy cycle of a write. It then expects the marker write, not the page data, with `busy` falling on that same clock. A second pairing drives a new command into the middle of a busy period, which must neither open a command nor shorten or lengthen the busy period.

// File: rtl/epw_pkg.sv
`timescale 1ns/1ps
package epw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_BURN = 2'd2
  } epw_state_e;
endpackage

// File: rtl/epw_page_buf.sv
`timescale 1ns/1ps
module epw_page_buf #(
  parameter int ADDR_W     = 9,
  parameter int PAGE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load,
  input  logic [ADDR_W-1:0]             load_addr,
  input  logic                          wr_en,
  input  logic [7:0]                    wr_data,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_num,
  output logic [PAGE_BYTES-1:0]         slot_mask,
  output logic [PAGE_BYTES*8-1:0]       page_data
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - IDX_W;

  logic [PG_W-1:0]       base_q;
  logic [IDX_W-1:0]      first_q;
  logic [IDX_W-1:0]      offs_q;
  logic [IDX_W-1:0]      slot;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            bytes_q [PAGE_BYTES];

  // modulo-page index: the add simply drops its carry
  assign slot = first_q + offs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      first_q <= '0;
      offs_q  <= '0;
      mask_q  <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) bytes_q[i] <= '0;
    end else if (load) begin
      base_q  <= load_addr[ADDR_W-1:IDX_W];
      first_q <= load_addr[IDX_W-1:0];
      offs_q  <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      bytes_q[slot] <= wr_data;
      mask_q[slot]  <= 1'b1;
      offs_q        <= offs_q + 1'b1;
    end
  end

  assign page_num  = base_q;
  assign slot_mask = mask_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign page_data[g*8 +: 8] = bytes_q[g];
  end

  p_slot_marked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load) |=> mask_q == ($past(mask_q) |
      ({{(PAGE_BYTES-1){1'b0}}, 1'b1} << $past(slot))));

  p_load_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mask_q == '0));
endmodule

// File: rtl/epw_timer.sv
`timescale 1ns/1ps
module epw_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run)           cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);

  p_cnt_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/epw_guard.sv
`timescale 1ns/1ps
module epw_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_take,
  input  logic in_fill,
  input  logic in_burn,
  input  logic d0_strobe,
  input  logic wp,
  output logic abort_fill,
  output logic abort_burn
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     armed_q <= 1'b0;
    else if (cmd_take)              armed_q <= 1'b0;
    else if (!in_fill && !in_burn)  armed_q <= 1'b0;
    else if (in_fill && d0_strobe)  armed_q <= 1'b1;
  end

  // cancel window opens on the first bit-0 sample edge itself
  assign abort_fill = in_fill && wp && (armed_q || d0_strobe);
  assign abort_burn = in_burn && wp;

  p_arm_after_d0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(d0_strobe));
endmodule

// File: rtl/eeprom_page_writer.sv
`timescale 1ns/1ps
module eeprom_page_writer
  import epw_pkg::*;
#(
  parameter int         ADDR_W     = 9,
  parameter int         PAGE_BYTES = 16,
  parameter int         TWR_CYCLES = 250000,
  parameter logic [7:0] MARKER     = 8'hEE
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 cmd_valid,
  input  logic [ADDR_W-1:0]                    cmd_addr,
  input  logic                                 d0_strobe,
  input  logic                                 in_valid,
  output logic                                 in_ready,
  input  logic [7:0]                           in_data,
  input  logic                                 stop_strobe,
  input  logic                                 wp,
  output logic                                 busy,
  output logic                                 mem_we,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] mem_page,
  output logic [PAGE_BYTES-1:0]                mem_be,
  output logic [PAGE_BYTES*8-1:0]              mem_wdata
);
  localparam int IDX_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - IDX_W;
  localparam int DW    = PAGE_BYTES * 8;

  epw_state_e state_q, state_d;

  logic                  cmd_take, buf_wr, t_done, ab_fill, ab_burn;
  logic [PG_W-1:0]       buf_page;
  logic [PAGE_BYTES-1:0] buf_mask;
  logic [DW-1:0]         buf_data;

  assign cmd_take = cmd_valid && (state_q != ST_BURN);
  assign in_ready = (state_q == ST_FILL);
  assign busy     = (state_q == ST_BURN);
  assign buf_wr   = in_valid && in_ready;

  epw_page_buf #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(cmd_take), .load_addr(cmd_addr),
    .wr_en(buf_wr), .wr_data(in_data), .page_num(buf_page),
    .slot_mask(buf_mask), .page_data(buf_data)
  );

  epw_timer #(.CYCLES(TWR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(busy), .done(t_done)
  );

  epw_guard u_grd (
    .clk(clk), .rst_n(rst_n), .cmd_take(cmd_take),
    .in_fill(state_q == ST_FILL), .in_burn(busy),
    .d0_strobe(d0_strobe), .wp(wp),
    .abort_fill(ab_fill), .abort_burn(ab_burn)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_take) state_d = ST_FILL;
      ST_FILL: begin
        if (cmd_take)         state_d = ST_FILL;
        else if (ab_fill)     state_d = ST_IDLE;
        else if (stop_strobe) state_d = ((|buf_mask) && !wp) ? ST_BURN : ST_IDLE;
      end
      ST_BURN: if (ab_burn || t_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      mem_we    <= 1'b0;
      mem_page  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else begin
      state_q <= state_d;
      mem_we  <= 1'b0;
      if (busy && (ab_burn || t_done)) begin
        mem_we    <= 1'b1;
        mem_page  <= buf_page;
        mem_be    <= buf_mask;
        mem_wdata <= ab_burn ? {PAGE_BYTES{MARKER}} : buf_data;
      end
    end
  end

  p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_we_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($past(busy) && !busy));

  p_abort_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wp) |=> (!busy && mem_we && mem_wdata == {PAGE_BYTES{MARKER}}));

  p_ready_idle_in_burn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wp && !t_done) |=> busy);

  p_be_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_be != '0));
endmodule

// File: tb/sim_eeprom_page_writer.sv
`timescale 1ns/1ps
module sim_eeprom_page_writer;
  localparam int TWR = 24;
  localparam int PB  = 16;
  localparam int DW  = PB * 8;
  localparam logic [7:0] MARK = 8'hEE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [8:0] cmd_addr = '0;
  logic d0_strobe = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = '0;
  logic stop_strobe = 1'b0;
  logic wp = 1'b0;
  logic busy, mem_we;
  logic [4:0] mem_page;
  logic [PB-1:0] mem_be;
  logic [DW-1:0] mem_wdata;

  always #10 clk = ~clk;

  eeprom_page_writer #(.TWR_CYCLES(TWR), .MARKER(MARK)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .d0_strobe(d0_strobe), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .stop_strobe(stop_strobe), .wp(wp), .busy(busy),
    .mem_we(mem_we), .mem_page(mem_page), .mem_be(mem_be), .mem_wdata(mem_wdata)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard queues
  logic [DW-1:0] q_data[$];
  logic [PB-1:0] q_be[$];
  logic [4:0]    q_page[$];
  string         q_tag[$];

  // bench page model
  logic [7:0]    e_bytes [PB];
  logic [PB-1:0] e_be;
  logic [4:0]    e_page;
  int            e_first, e_n;

  int blen = 0;
  int last_len = 0;
  bit busy_prev = 1'b0;

  // monitor: compares every write and measures busy periods
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) blen++;
      else if (busy_prev) begin last_len = blen; blen = 0; end
      busy_prev = busy;
      if (mem_we) begin
        if (q_be.size() == 0) begin
          chk(1'b0, "R5 unexpected write", {123'd0, mem_page}, '0);
        end else begin
          logic [DW-1:0] xd;
          logic [PB-1:0] xb;
          logic [4:0]    xp;
          string         tg;
          bit ok;
          xd = q_data.pop_front(); xb = q_be.pop_front();
          xp = q_page.pop_front(); tg = q_tag.pop_front();
          chk(mem_page == xp, {tg, " page"}, {123'd0, mem_page}, {123'd0, xp});
          chk(mem_be == xb, {"R11 mask ", tg}, {112'd0, mem_be}, {112'd0, xb});
          ok = 1'b1;
          for (int i = 0; i < PB; i++)
            if (xb[i] && mem_wdata[i*8 +: 8] != xd[i*8 +: 8]) ok = 1'b0;
          chk(ok, {tg, " data"}, mem_wdata, xd);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic start_cmd(input logic [8:0] a);
    cmd_valid = 1'b1; cmd_addr = a;
    tick();
    cmd_valid = 1'b0;
    e_page = a[8:4]; e_first = int'(a[3:0]); e_n = 0; e_be = '0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    int s;
    d0_strobe = 1'b1;
    tick();
    d0_strobe = 1'b0;
    in_valid = 1'b1; in_data = b;
    chk(in_ready == 1'b1, "R2 ready for byte", {127'd0, in_ready}, 1);
    tick();
    in_valid = 1'b0;
    s = (e_first + e_n) % PB;
    e_bytes[s] = b; e_be[s] = 1'b1; e_n++;
  endtask

  task automatic push_expect(input bit marker, input string tag);
    logic [DW-1:0] d;
    for (int i = 0; i < PB; i++) d[i*8 +: 8] = marker ? MARK : e_bytes[i];
    q_data.push_back(d); q_be.push_back(e_be);
    q_page.push_back(e_page); q_tag.push_back(tag);
  endtask

  task automatic send_stop();
    stop_strobe = 1'b1;
    tick();
    stop_strobe = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int guard = 0;
    while (busy && guard < 1000) begin tick(); guard++; end
    chk(last_len == TWR, tag, last_len, TWR);
    chk(mem_we == 1'b1, {tag, " we at busy fall"}, {127'd0, mem_we}, 1);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < PB; i++) e_bytes[i] = '0;
    repeat (3) tick();
    chk(busy == 0, "R1 busy", {127'd0, busy}, 0);
    chk(in_ready == 0, "R1 in_ready", {127'd0, in_ready}, 0);
    chk(mem_we == 0, "R1 mem_we", {127'd0, mem_we}, 0);
    rst_n = 1'b1;
    tick();

    // R3: wrap inside the page, page-select bit set
    start_cmd(9'h10E);
    chk(in_ready == 1, "R2 ready after cmd", {127'd0, in_ready}, 1);
    send_byte(8'hA0); send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3);
    chk(busy == 0 && mem_we == 0, "R5 no write before stop", {126'd0, busy, mem_we}, 0);
    push_expect(1'b0, "R3 wrap");
    send_stop();
    chk(busy == 1, "R5 busy after stop", {127'd0, busy}, 1);
    wait_idle("R5 busy length");

    // R4: 20 bytes overwrite from first slot
    start_cmd(9'h035);
    for (int k = 0; k < 20; k++) send_byte(8'(8'h40 + k));
    push_expect(1'b0, "R4 overflow");
    send_stop();
    wait_idle("R4 busy length");

    // R6: stop without data
    start_cmd(9'h0C3);
    send_stop();
    chk(busy == 0, "R6 no busy", {127'd0, busy}, 0);
    repeat (3) tick();
    chk(busy == 0 && mem_we == 0, "R6 still idle", {126'd0, busy, mem_we}, 0);

    // R7: wp high before first bit-0 sample is ignored
    start_cmd(9'h151);
    wp = 1'b1; repeat (2) tick(); wp = 1'b0;
    chk(in_ready == 1, "R7 command kept", {127'd0, in_ready}, 1);
    send_byte(8'h5A); send_byte(8'hC3);
    push_expect(1'b0, "R7 normal write");
    send_stop();
    wait_idle("R7 busy length");

    // R8: wp high after first bit-0 sample during collection
    start_cmd(9'h077);
    send_byte(8'h11);
    wp = 1'b1;
    tick();
    chk(in_ready == 0, "R8 command dropped", {127'd0, in_ready}, 0);
    wp = 1'b0;
    send_stop();
    chk(busy == 0, "R8 no busy", {127'd0, busy}, 0);
    repeat (3) tick();
    chk(mem_we == 0, "R8 no write", {127'd0, mem_we}, 0);

    // R9: cancel mid write
    start_cmd(9'h0A0);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
    push_expect(1'b1, "R9 marker mid");
    send_stop();
    repeat (4) tick();
    wp = 1'b1;
    tick();
    wp = 1'b0;
    chk(busy == 0 && mem_we == 1, "R9 standby at once", {126'd0, busy, mem_we}, 1);
    start_cmd(9'h1F8);
    chk(in_ready == 1, "R9 new cmd accepted", {127'd0, in_ready}, 1);

    // R9: cancel on the final busy cycle wins over completion
    send_byte(8'h77); send_byte(8'h88);
    push_expect(1'b1, "R9 marker last cycle");
    send_stop();
    repeat (TWR - 1) tick();
    chk(busy == 1, "R9 still busy on last cycle", {127'd0, busy}, 1);
    wp = 1'b1;
    tick();
    wp = 1'b0;
    chk(busy == 0 && mem_we == 1, "R9 collision result", {126'd0, busy, mem_we}, 1);

    // R10: command while busy is ignored
    start_cmd(9'h062);
    send_byte(8'h9D);
    push_expect(1'b0, "R10 write unaffected");
    send_stop();
    repeat (3) tick();
    cmd_valid = 1'b1; cmd_addr = 9'h1AA;
    tick();
    cmd_valid = 1'b0;
    chk(in_ready == 0, "R10 no command opened", {127'd0, in_ready}, 0);
    wait_idle("R10 busy length");

    repeat (3) tick();
    chk(q_be.size() == 0, "R5 all writes seen", q_be.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule